// File: doc/BRIEF.md
# Digital PLL Operating Mode Controller

This block runs the mode sequence of a single digital clock-synthesis loop. It reads the qualification flags of four candidate reference inputs, the loop's loss-of-lock indication and the status of its averaged frequency history. From these it moves the loop between free-run, lock acquisition, locked and holdover. When more than one input is usable it picks the lowest-numbered one, and it falls back to another usable input before it gives up on external references.

It also chooses the loop-filter bandwidth that the loop uses. There are three sets: the normal loop bandwidth, a wider fastlock bandwidth, and a bandwidth used when the loop leaves holdover. The choice depends on the loss-of-lock state and the configuration bits. On a holdover exit the block either names the exit bandwidth or asks for a frequency ramp. The three bandwidth codes are copied from pending values only when an update strobe arrives. A sticky holdover flag, cleared by writing zero, drives a maskable interrupt line.

All mode transitions are registered on the system clock. The bandwidth selection, the ramp request and the live holdover flag are decoded from the registered state and the current configuration inputs.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While reset is active the mode is free-run, the selected index is 0, the bandwidth selection is loop, the ramp request is low and the sticky flag and interrupt are low. Mode encoding: 00 free-run, 01 acquisition, 10 locked, 11 holdover.
- R2: In free-run, if any input is valid, the next cycle is acquisition with the lowest-numbered valid input selected. With no valid input the mode stays in free-run.
- R3: In acquisition, with the selected input valid and loss-of-lock low, the next cycle is locked. In locked, with the selected input valid and loss-of-lock high, the next cycle is acquisition.
- R4: If the selected input becomes invalid while in acquisition or locked and another input is valid, the next cycle is acquisition with the lowest-numbered valid input selected.
- R5: If the selected input fails and no input is valid, the next mode is holdover when history is valid and free-run when it is not.
- R6: In holdover, when any input becomes valid, the next cycle is acquisition on the lowest-numbered valid input.
- R7: While force-holdover is high the mode is holdover from the following cycle on, whatever the inputs. After it is released the mode leaves holdover by the rule of R6.
- R8: Bandwidth selection encoding: 00 loop, 01 fastlock, 10 holdover-exit. The force-fastlock bit selects fastlock unconditionally. Otherwise, outside a bypassed holdover exit, fastlock is selected while auto-fastlock is enabled and loss-of-lock is high, and loop is selected in all other cases.
- R9: During acquisition entered from holdover: with ramp bypass set, the 2-bit exit select chooses the bandwidth (00 fastlock, 01 holdover-exit, 10 or 11 loop) and the ramp request is low. With ramp bypass clear, the ramp request is high. The exit phase ends when the mode leaves acquisition.
- R10: The live holdover flag is high in holdover and in free-run. Its sticky copy is set by it. A write strobe with data 0 clears the sticky copy when the live flag is low. A write with data 1 has no effect.
- R11: The interrupt is the sticky flag gated by the mask bit. Mask 1 blocks the interrupt.
- R12: The bandwidth value output is the latched code of the selected bandwidth. The pending loop, fastlock and exit codes are latched together on the update strobe, and changing them without the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | N_IN | Qualified flag per candidate input |
| lol | input | 1 | Loss-of-lock from the loop |
| hist_valid | input | 1 | Averaged history usable for holdover |
| force_hold | input | 1 | Force the loop into holdover |
| fl_auto_en | input | 1 | Enable automatic fastlock during loss-of-lock |
| fl_force | input | 1 | Force fastlock bandwidth |
| ramp_bypass | input | 1 | Use exit select instead of a frequency ramp on holdover exit |
| exit_bw_sel | input | 2 | Bandwidth choice on bypassed holdover exit |
| loop_bw_pend | input | BW_W | Pending normal loop bandwidth code |
| fast_bw_pend | input | BW_W | Pending fastlock bandwidth code |
| exit_bw_pend | input | BW_W | Pending holdover-exit bandwidth code |
| bw_update | input | 1 | Strobe latching all three pending codes |
| sticky_wr | input | 1 | Write strobe for the sticky holdover flag |
| sticky_wdata | input | 1 | Write data; 0 clears |
| irq_mask | input | 1 | Interrupt mask, 1 blocks |
| mode | output | 2 | Current operating mode |
| sel_idx | output | IDX_W | Index of the selected input |
| bw_sel | output | 2 | Active bandwidth selection |
| bw_value | output | BW_W | Latched code of the active bandwidth |
| ramp_req | output | 1 | Frequency ramp request on holdover exit |
| hold_flag | output | 1 | Live holdover status |
| hold_sticky | output | 1 | Sticky holdover status |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check every single-cycle transition rule on every cycle: free-run exit, lock entry and loss, the holdover and free-run fallback, holdover exit, force-holdover, force-fastlock precedence, the mask gating, sticky setting and the stability of the bandwidth value between strobes. Other behaviours can only be shown by the bench's scenarios, because they depend on history. These include priority among several valid inputs, switching inputs after a failure, the full decoding of the exit select and the ramp request after a real holdover exit, clearing the sticky flag by software, and the fact that pending codes have no effect until the strobe.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_ACQ  = 2'b01,
        MODE_LOCK = 2'b10,
        MODE_HOLD = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        BW_LOOP = 2'b00,
        BW_FAST = 2'b01,
        BW_EXIT = 2'b10
    } bw_e;
endpackage

// File: rtl/mc_arbiter.sv
module mc_arbiter #(
    parameter int N_IN  = 4,
    parameter int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [N_IN-1:0]  valid,
    output logic             any,
    output logic [IDX_W-1:0] pick
);
    logic [N_IN-1:0] first;

    genvar g;
    generate
        for (g = 0; g < N_IN; g++) begin : g_first
            if (g == 0) begin : g_lo
                assign first[g] = valid[g];
            end else begin : g_hi
                assign first[g] = valid[g] & ~(|valid[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        pick = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (first[i]) pick = pick | IDX_W'(i);
        end
    end

    assign any = |valid;
endmodule

// File: rtl/mc_bw_bank.sv
module mc_bw_bank
    import mc_pkg::*;
#(
    parameter int              BW_W     = 6,
    parameter logic [BW_W-1:0] LOOP_RST = 4,
    parameter logic [BW_W-1:0] FAST_RST = 20,
    parameter logic [BW_W-1:0] EXIT_RST = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic [BW_W-1:0] loop_pend,
    input  logic [BW_W-1:0] fast_pend,
    input  logic [BW_W-1:0] exit_pend,
    input  bw_e             which,
    output logic [BW_W-1:0] value
);
    typedef struct packed {
        logic [BW_W-1:0] loop_bw;
        logic [BW_W-1:0] fast_bw;
        logic [BW_W-1:0] exit_bw;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (upd) begin
            bank_d.loop_bw = loop_pend;
            bank_d.fast_bw = fast_pend;
            bank_d.exit_bw = exit_pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '{loop_bw: LOOP_RST, fast_bw: FAST_RST, exit_bw: EXIT_RST};
        else        bank_q <= bank_d;
    end

    always_comb begin
        case (which)
            BW_FAST: value = bank_q.fast_bw;
            BW_EXIT: value = bank_q.exit_bw;
            default: value = bank_q.loop_bw;
        endcase
    end
endmodule

// File: rtl/mc_status.sv
module mc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic wr,
    input  logic wdata,
    input  logic mask,
    output logic sticky,
    output logic irq
);
    logic sticky_d, sticky_q;

    always_comb begin
        sticky_d = sticky_q;
        if (wr && !wdata) sticky_d = 1'b0;
        if (live)         sticky_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= 1'b0;
        else        sticky_q <= sticky_d;
    end

    assign sticky = sticky_q;
    assign irq    = sticky_q & ~mask;
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
    import mc_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int BW_W  = 6,
    parameter int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_valid,
    input  logic             lol,
    input  logic             hist_valid,
    input  logic             force_hold,
    input  logic             fl_auto_en,
    input  logic             fl_force,
    input  logic             ramp_bypass,
    input  logic [1:0]       exit_bw_sel,
    input  logic [BW_W-1:0]  loop_bw_pend,
    input  logic [BW_W-1:0]  fast_bw_pend,
    input  logic [BW_W-1:0]  exit_bw_pend,
    input  logic             bw_update,
    input  logic             sticky_wr,
    input  logic             sticky_wdata,
    input  logic             irq_mask,
    output logic [1:0]       mode,
    output logic [IDX_W-1:0] sel_idx,
    output logic [1:0]       bw_sel,
    output logic [BW_W-1:0]  bw_value,
    output logic             ramp_req,
    output logic             hold_flag,
    output logic             hold_sticky,
    output logic             irq
);
    typedef struct packed {
        mode_e            mode;
        logic [IDX_W-1:0] sel;
        logic             from_hold;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             any_ok;
    logic [IDX_W-1:0] best;
    logic             cur_ok;
    logic             exit_phase;
    bw_e              bw_pick;

    mc_arbiter #(.N_IN(N_IN), .IDX_W(IDX_W)) i_arb (
        .valid (in_valid),
        .any   (any_ok),
        .pick  (best)
    );

    assign cur_ok = in_valid[ctl_q.sel];

    always_comb begin
        ctl_d = ctl_q;
        if (force_hold) begin
            ctl_d.mode      = MODE_HOLD;
            ctl_d.from_hold = 1'b0;
        end else begin
            case (ctl_q.mode)
                MODE_FREE, MODE_HOLD: begin
                    if (any_ok) begin
                        ctl_d.mode      = MODE_ACQ;
                        ctl_d.sel       = best;
                        ctl_d.from_hold = (ctl_q.mode == MODE_HOLD);
                    end
                end
                default: begin
                    if (!cur_ok) begin
                        if (any_ok) begin
                            ctl_d.mode = MODE_ACQ;
                            ctl_d.sel  = best;
                        end else begin
                            ctl_d.mode      = hist_valid ? MODE_HOLD : MODE_FREE;
                            ctl_d.from_hold = 1'b0;
                        end
                    end else if (ctl_q.mode == MODE_ACQ && !lol) begin
                        ctl_d.mode      = MODE_LOCK;
                        ctl_d.from_hold = 1'b0;
                    end else if (ctl_q.mode == MODE_LOCK && lol) begin
                        ctl_d.mode = MODE_ACQ;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: MODE_FREE, sel: '0, from_hold: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign exit_phase = (ctl_q.mode == MODE_ACQ) && ctl_q.from_hold;

    always_comb begin
        if (fl_force) begin
            bw_pick = BW_FAST;
        end else if (exit_phase && ramp_bypass) begin
            case (exit_bw_sel)
                2'b00:   bw_pick = BW_FAST;
                2'b01:   bw_pick = BW_EXIT;
                default: bw_pick = BW_LOOP;
            endcase
        end else if (fl_auto_en && lol) begin
            bw_pick = BW_FAST;
        end else begin
            bw_pick = BW_LOOP;
        end
    end

    mc_bw_bank #(.BW_W(BW_W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (bw_update),
        .loop_pend (loop_bw_pend),
        .fast_pend (fast_bw_pend),
        .exit_pend (exit_bw_pend),
        .which     (bw_pick),
        .value     (bw_value)
    );

    assign hold_flag = (ctl_q.mode == MODE_HOLD) || (ctl_q.mode == MODE_FREE);

    mc_status i_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .live   (hold_flag),
        .wr     (sticky_wr),
        .wdata  (sticky_wdata),
        .mask   (irq_mask),
        .sticky (hold_sticky),
        .irq    (irq)
    );

    assign mode     = ctl_q.mode;
    assign sel_idx  = ctl_q.sel;
    assign bw_sel   = bw_pick;
    assign ramp_req = exit_phase && !ramp_bypass;
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
    parameter int N_IN  = 4,
    parameter int BW_W  = 6,
    parameter int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  in_valid,
    input logic             lol,
    input logic             hist_valid,
    input logic             force_hold,
    input logic             fl_force,
    input logic             ramp_bypass,
    input logic             bw_update,
    input logic             irq_mask,
    input logic [1:0]       mode,
    input logic [IDX_W-1:0] sel_idx,
    input logic [1:0]       bw_sel,
    input logic [BW_W-1:0]  bw_value,
    input logic             ramp_req,
    input logic             hold_flag,
    input logic             hold_sticky,
    input logic             irq
);
    localparam logic [1:0] M_FREE = 2'b00;
    localparam logic [1:0] M_ACQ  = 2'b01;
    localparam logic [1:0] M_LOCK = 2'b10;
    localparam logic [1:0] M_HOLD = 2'b11;

    logic sel_ok;
    assign sel_ok = in_valid[sel_idx];

    p_free_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_FREE && !force_hold && |in_valid) |=> (mode == M_ACQ));

    p_lock_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ACQ && !force_hold && sel_ok && !lol) |=> (mode == M_LOCK));

    p_lock_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_LOCK && !force_hold && sel_ok && lol) |=> (mode == M_ACQ));

    p_to_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_ACQ || mode == M_LOCK) && !force_hold && in_valid == '0 && hist_valid)
        |=> (mode == M_HOLD));

    p_to_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_ACQ || mode == M_LOCK) && !force_hold && in_valid == '0 && !hist_valid)
        |=> (mode == M_FREE));

    p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_HOLD && !force_hold && |in_valid) |=> (mode == M_ACQ));

    p_force_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        force_hold |=> (mode == M_HOLD));

    p_fast_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_force |-> (bw_sel == 2'b01));

    p_no_ramp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_bypass || mode != M_ACQ) |-> !ramp_req);

    p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_flag |=> hold_sticky);

    p_live_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_flag == (mode == M_HOLD || mode == M_FREE));

    p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask || !hold_sticky) |-> !irq);

    p_bw_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!bw_update ##1 $stable(bw_sel)) |-> $stable(bw_value));
endmodule

bind pll_mode_ctrl mc_checker #(.N_IN(N_IN), .BW_W(BW_W), .IDX_W(IDX_W)) i_mc_checker (.*);

// File: tb/test_pll_mode_ctrl.sv
module test_pll_mode_ctrl;
    localparam int N_IN  = 4;
    localparam int BW_W  = 6;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_IN-1:0]  in_valid = '0;
    logic             lol = 1'b0;
    logic             hist_valid = 1'b0;
    logic             force_hold = 1'b0;
    logic             fl_auto_en = 1'b0;
    logic             fl_force = 1'b0;
    logic             ramp_bypass = 1'b0;
    logic [1:0]       exit_bw_sel = 2'b01;
    logic [BW_W-1:0]  loop_bw_pend = '0;
    logic [BW_W-1:0]  fast_bw_pend = '0;
    logic [BW_W-1:0]  exit_bw_pend = '0;
    logic             bw_update = 1'b0;
    logic             sticky_wr = 1'b0;
    logic             sticky_wdata = 1'b0;
    logic             irq_mask = 1'b0;
    logic [1:0]       mode;
    logic [IDX_W-1:0] sel_idx;
    logic [1:0]       bw_sel;
    logic [BW_W-1:0]  bw_value;
    logic             ramp_req;
    logic             hold_flag;
    logic             hold_sticky;
    logic             irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pll_mode_ctrl #(.N_IN(N_IN), .BW_W(BW_W)) i_pll_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lol(lol),
        .hist_valid(hist_valid), .force_hold(force_hold),
        .fl_auto_en(fl_auto_en), .fl_force(fl_force),
        .ramp_bypass(ramp_bypass), .exit_bw_sel(exit_bw_sel),
        .loop_bw_pend(loop_bw_pend), .fast_bw_pend(fast_bw_pend),
        .exit_bw_pend(exit_bw_pend), .bw_update(bw_update),
        .sticky_wr(sticky_wr), .sticky_wdata(sticky_wdata),
        .irq_mask(irq_mask), .mode(mode), .sel_idx(sel_idx),
        .bw_sel(bw_sel), .bw_value(bw_value), .ramp_req(ramp_req),
        .hold_flag(hold_flag), .hold_sticky(hold_sticky), .irq(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "mode in reset", mode, 0);
        check("R1", "sel in reset", sel_idx, 0);
        check("R1", "bw_sel in reset", bw_sel, 0);
        check("R1", "bw_value in reset", bw_value, 4);
        check("R1", "ramp in reset", ramp_req, 0);
        check("R1", "sticky in reset", hold_sticky, 0);
        check("R1", "irq in reset", irq, 0);
        rst_n = 1'b1;
        tick();
        check("R2", "stays free with no input", mode, 0);
        check("R10", "live flag in free-run", hold_flag, 1);
        check("R10", "sticky set from free-run", hold_sticky, 1);
        check("R11", "irq unmasked", irq, 1);
    endtask

    task automatic t_acquire();
        in_valid = 4'b0110; fl_auto_en = 1'b1; lol = 1'b1;
        tick();
        check("R2", "free to acquisition", mode, 1);
        check("R2", "lowest valid picked", sel_idx, 1);
        check("R8", "auto fastlock on lol", bw_sel, 1);
        check("R10", "live flag low in acq", hold_flag, 0);
        lol = 1'b0;
        tick();
        check("R3", "acq to locked", mode, 2);
        check("R8", "loop bw when locked", bw_sel, 0);
        lol = 1'b1;
        tick();
        check("R3", "locked back to acq on lol", mode, 1);
        lol = 1'b0;
        tick();
        check("R3", "relocked", mode, 2);
    endtask

    task automatic t_switch();
        in_valid = 4'b0100;
        tick();
        check("R4", "switch to acq", mode, 1);
        check("R4", "new input picked", sel_idx, 2);
        tick();
        check("R4", "locked on new input", mode, 2);
    endtask

    task automatic t_sticky();
        irq_mask = 1'b1; #1;
        check("R11", "mask blocks irq", irq, 0);
        irq_mask = 1'b0; #1;
        check("R11", "irq follows sticky", irq, 1);
        sticky_wr = 1'b1; sticky_wdata = 1'b1;
        tick();
        check("R10", "write 1 no effect", hold_sticky, 1);
        sticky_wdata = 1'b0;
        tick();
        sticky_wr = 1'b0;
        check("R10", "write 0 clears", hold_sticky, 0);
        check("R11", "irq gone after clear", irq, 0);
    endtask

    task automatic t_holdover();
        hist_valid = 1'b1; in_valid = 4'b0000;
        tick();
        check("R5", "fail with history to holdover", mode, 3);
        check("R10", "live flag in holdover", hold_flag, 1);
        tick();
        check("R10", "sticky set in holdover", hold_sticky, 1);
        in_valid = 4'b1000; ramp_bypass = 1'b1; exit_bw_sel = 2'b01; lol = 1'b1;
        tick();
        check("R6", "holdover to acq", mode, 1);
        check("R6", "exit input", sel_idx, 3);
        check("R9", "exit sel 01 holdover-exit bw", bw_sel, 2);
        check("R9", "no ramp when bypassed", ramp_req, 0);
        exit_bw_sel = 2'b00; #1;
        check("R9", "exit sel 00 fastlock", bw_sel, 1);
        exit_bw_sel = 2'b11; #1;
        check("R9", "exit sel 11 loop", bw_sel, 0);
        exit_bw_sel = 2'b10; #1;
        check("R9", "exit sel 10 loop", bw_sel, 0);
        ramp_bypass = 1'b0; #1;
        check("R9", "ramp requested", ramp_req, 1);
        check("R8", "auto fastlock during ramp", bw_sel, 1);
        lol = 1'b0;
        tick();
        check("R9", "locked after exit", mode, 2);
        check("R9", "ramp ends", ramp_req, 0);
    endtask

    task automatic t_freerun();
        hist_valid = 1'b0; in_valid = 4'b0000;
        tick();
        check("R5", "fail without history to free-run", mode, 0);
    endtask

    task automatic t_force();
        in_valid = 4'b0001;
        tick();
        check("R2", "acq on input 0", mode, 1);
        check("R2", "sel 0", sel_idx, 0);
        force_hold = 1'b1;
        tick();
        check("R7", "forced holdover", mode, 3);
        tick();
        check("R7", "holdover kept with valid input", mode, 3);
        force_hold = 1'b0;
        tick();
        check("R7", "leaves holdover after release", mode, 1);
        check("R9", "ramp after forced exit", ramp_req, 1);
        tick();
        check("R3", "locks after forced exit", mode, 2);
    endtask

    task automatic t_fastforce();
        fl_auto_en = 1'b0; lol = 1'b0; fl_force = 1'b1; #1;
        check("R8", "force fastlock", bw_sel, 1);
        check("R12", "fast default value", bw_value, 20);
        fl_force = 1'b0; #1;
        check("R8", "release force", bw_sel, 0);
    endtask

    task automatic t_bw();
        loop_bw_pend = 6'd33; fast_bw_pend = 6'd44; exit_bw_pend = 6'd55;
        tick();
        check("R12", "pending ignored without strobe", bw_value, 4);
        bw_update = 1'b1;
        tick();
        bw_update = 1'b0;
        check("R12", "loop code latched", bw_value, 33);
        fl_force = 1'b1; #1;
        check("R12", "fast code latched", bw_value, 44);
        fl_force = 1'b0;
        hist_valid = 1'b1; in_valid = 4'b0000;
        tick();
        check("R5", "holdover again", mode, 3);
        in_valid = 4'b0011; ramp_bypass = 1'b1; exit_bw_sel = 2'b01; lol = 1'b1;
        tick();
        check("R6", "lowest of two picked", sel_idx, 0);
        check("R12", "exit code latched", bw_value, 55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_acquire();
        t_switch();
        t_sticky();
        t_holdover();
        t_freerun();
        t_force();
        t_fastforce();
        t_bw();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule